// File: doc/BRIEF.md
# Counting Semaphore Bank for Tile Message Queues

This block sits in each processing tile and holds a small array of counting semaphores used to coordinate producer/consumer message queues kept in the tile's scratchpad. The tile's own core reaches the bank through a local port. With it the core can read a count, try to take a number of units atomically, or give units back. None of these steps needs the on-chip interconnect.

Other tiles reach the bank through a remote slave port that accepts single posted writes. Each write adds an amount to one semaphore. A consumer tile uses such a write to tell a producer that slots have been freed, and a producer uses one to tell a consumer that a message has arrived. When a remote add and a local operation hit the same semaphore in the same cycle, they are merged into one net update, so neither is lost.

Counts never exceed a configured queue depth. An add that would go past that depth clips the count at the depth and raises a sticky overflow flag for that semaphore.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore holds INIT_CNT, every overflow flag is 0, and `loc_rsp_vld` is 0.
- R2: A local request gets a response exactly one cycle later. `loc_rsp_vld` is high in that cycle only. `loc_rsp_cnt` carries the count of the addressed semaphore as it stood in the request cycle. Op 0 (peek) returns ok=1 and leaves the count unchanged. Op 3 behaves as a peek.
- R3: Op 1 (take) with amount N succeeds when the count is at least N. It then returns ok=1 and lowers the count by N.
- R4: A take with amount N against a count below N returns ok=0 and leaves the count unchanged.
- R5: A remote write with `rmt_wr`=1 adds `rmt_amt` to the semaphore selected by `rmt_idx`. The new value is visible from the next cycle, and the write produces no response.
- R6: A remote add and a local take on the same semaphore in the same cycle are both applied. The take is judged against the count before the add.
- R7: Any update whose result exceeds MAX_DEPTH leaves the count at MAX_DEPTH and sets that semaphore's bit in `ovf`. The bit then stays set until reset. No count ever exceeds MAX_DEPTH.
- R8: Op 2 (give) with amount N adds N to the addressed semaphore and returns ok=1.
- R9: A semaphore that is addressed by neither port in a cycle keeps its count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req | input | 1 | Local operation request |
| loc_op | input | 2 | 0 peek, 1 take, 2 give, 3 peek |
| loc_idx | input | $clog2(NSEM) | Local semaphore index |
| loc_amt | input | CW | Amount for take or give |
| rmt_wr | input | 1 | Remote posted increment write |
| rmt_idx | input | $clog2(NSEM) | Remote semaphore index |
| rmt_amt | input | CW | Remote increment amount |
| loc_rsp_vld | output | 1 | Local response valid |
| loc_rsp_ok | output | 1 | Take succeeded (always 1 for other ops) |
| loc_rsp_cnt | output | CW | Count seen by the request |
| ovf | output | NSEM | Sticky per-semaphore overflow flags |

## Verification
The bench builds the bank with eight 8-bit semaphores, a reset count of 4 and a queue depth of 12. With a depth that small, a single remote write or a short run of gives can cross the ceiling, so clipping and the sticky overflow flag are reached within a handful of cycles rather than after hundreds of increments. A starting count of 4 lets the very first takes probe both sides of the success boundary. A long mixed phase then drives both ports together on colliding and distinct indices.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OP_PEEK  = 2'd0,
      OP_TAKE  = 2'd1,
      OP_GIVE  = 2'd2,
      OP_PEEK2 = 2'd3
   } sem_op_e;
endpackage

// File: rtl/sem_route.sv
module sem_route
   import sem_pkg::*;
#(
   parameter int NSEM = 8,
   parameter int IDXW = $clog2(NSEM)
) (
   input  logic            loc_req,
   input  logic [1:0]      loc_op,
   input  logic [IDXW-1:0] loc_idx,
   input  logic            rmt_wr,
   input  logic [IDXW-1:0] rmt_idx,
   output logic [NSEM-1:0] take_hit,
   output logic [NSEM-1:0] give_hit,
   output logic [NSEM-1:0] rmt_hit
);
   for (genvar s = 0; s < NSEM; s++) begin : g_sel
      logic loc_here;
      assign loc_here    = loc_req && (loc_idx == IDXW'(s));
      assign take_hit[s] = loc_here && (sem_op_e'(loc_op) == OP_TAKE);
      assign give_hit[s] = loc_here && (sem_op_e'(loc_op) == OP_GIVE);
      assign rmt_hit[s]  = rmt_wr && (rmt_idx == IDXW'(s));
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
   parameter int CW        = 8,
   parameter int MAX_DEPTH = 255,
   parameter int INIT_CNT  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_take,
   input  logic          l_give,
   input  logic [CW-1:0] l_amt,
   input  logic          r_inc,
   input  logic [CW-1:0] r_amt,
   output logic [CW-1:0] cnt,
   output logic          ovf,
   output logic          enough
);
   localparam int SW = CW + 2;
   localparam logic [SW-1:0] CAP = SW'(MAX_DEPTH);

   logic [CW-1:0] cnt_q;
   logic          ovf_q;
   logic [SW-1:0] add_l, add_r, raised, net;
   logic          clip;
   logic [CW-1:0] cnt_d;

   assign enough = (cnt_q >= l_amt);

   always_comb begin
      add_l  = l_give ? SW'(l_amt) : '0;
      add_r  = r_inc  ? SW'(r_amt) : '0;
      raised = SW'(cnt_q) + add_l + add_r;
      net    = (l_take && enough) ? (raised - SW'(l_amt)) : raised;
      clip   = (net > CAP);
      cnt_d  = clip ? CW'(MAX_DEPTH) : net[CW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CW'(INIT_CNT);
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (clip) ovf_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;
endmodule

// File: rtl/sem_resp.sv
module sem_resp
   import sem_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [1:0]    op,
   input  logic [CW-1:0] sel_cnt,
   input  logic          sel_enough,
   output logic          rsp_vld,
   output logic          rsp_ok,
   output logic [CW-1:0] rsp_cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         rsp_ok  <= 1'b0;
         rsp_cnt <= '0;
      end else begin
         rsp_vld <= req;
         if (req) begin
            rsp_cnt <= sel_cnt;
            rsp_ok  <= (sem_op_e'(op) == OP_TAKE) ? sel_enough : 1'b1;
         end
      end
   end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NSEM      = 8,
   parameter int CW        = 8,
   parameter int MAX_DEPTH = (1 << CW) - 1,
   parameter int INIT_CNT  = 0,
   parameter int IDXW      = $clog2(NSEM)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            loc_req,
   input  logic [1:0]      loc_op,
   input  logic [IDXW-1:0] loc_idx,
   input  logic [CW-1:0]   loc_amt,
   input  logic            rmt_wr,
   input  logic [IDXW-1:0] rmt_idx,
   input  logic [CW-1:0]   rmt_amt,
   output logic            loc_rsp_vld,
   output logic            loc_rsp_ok,
   output logic [CW-1:0]   loc_rsp_cnt,
   output logic [NSEM-1:0] ovf
);
   if (NSEM < 2 || (1 << IDXW) < NSEM) begin : g_bad_nsem
      $error("sem_bank: NSEM must be at least 2 and fit the index width");
   end
   if (MAX_DEPTH < 1 || MAX_DEPTH >= (1 << CW)) begin : g_bad_depth
      $error("sem_bank: MAX_DEPTH must lie in 1 .. 2**CW-1");
   end
   if (INIT_CNT < 0 || INIT_CNT > MAX_DEPTH) begin : g_bad_init
      $error("sem_bank: INIT_CNT must not exceed MAX_DEPTH");
   end

   logic [NSEM-1:0]    take_hit, give_hit, rmt_hit, enough_vec;
   logic [NSEM*CW-1:0] cnt_flat;
   logic [CW-1:0]      sel_cnt;
   logic               sel_enough;

   sem_route #(.NSEM(NSEM), .IDXW(IDXW)) u_route (
      .loc_req (loc_req),
      .loc_op  (loc_op),
      .loc_idx (loc_idx),
      .rmt_wr  (rmt_wr),
      .rmt_idx (rmt_idx),
      .take_hit(take_hit),
      .give_hit(give_hit),
      .rmt_hit (rmt_hit)
   );

   for (genvar s = 0; s < NSEM; s++) begin : g_cell
      sem_cell #(.CW(CW), .MAX_DEPTH(MAX_DEPTH), .INIT_CNT(INIT_CNT)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .l_take (take_hit[s]),
         .l_give (give_hit[s]),
         .l_amt  (loc_amt),
         .r_inc  (rmt_hit[s]),
         .r_amt  (rmt_amt),
         .cnt    (cnt_flat[s*CW +: CW]),
         .ovf    (ovf[s]),
         .enough (enough_vec[s])
      );
   end

   assign sel_cnt    = cnt_flat[loc_idx*CW +: CW];
   assign sel_enough = enough_vec[loc_idx];

   sem_resp #(.CW(CW)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (loc_req),
      .op        (loc_op),
      .sel_cnt   (sel_cnt),
      .sel_enough(sel_enough),
      .rsp_vld   (loc_rsp_vld),
      .rsp_ok    (loc_rsp_ok),
      .rsp_cnt   (loc_rsp_cnt)
   );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
   parameter int NSEM      = 8,
   parameter int CW        = 8,
   parameter int MAX_DEPTH = 255,
   parameter int IDXW      = $clog2(NSEM)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            loc_req,
   input logic [1:0]      loc_op,
   input logic [IDXW-1:0] loc_idx,
   input logic [CW-1:0]   loc_amt,
   input logic            rmt_wr,
   input logic [IDXW-1:0] rmt_idx,
   input logic            loc_rsp_vld,
   input logic            loc_rsp_ok,
   input logic [CW-1:0]   loc_rsp_cnt,
   input logic [NSEM-1:0] ovf,
   input logic [NSEM*CW-1:0] cnt_flat
);
   logic [CW-1:0]   seen;
   logic [CW-1:0]   seen_q;
   logic [IDXW-1:0] idx_q;
   logic [CW-1:0]   after_cnt;

   assign seen      = cnt_flat[loc_idx*CW +: CW];
   assign after_cnt = cnt_flat[idx_q*CW +: CW];

   always_ff @(posedge clk) begin
      seen_q <= seen;
      idx_q  <= loc_idx;
   end

   // R2
   rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_req |=> loc_rsp_vld);

   // R2
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_req |=> !loc_rsp_vld);

   // R2
   peek_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && loc_op == 2'd0 && !(rmt_wr && rmt_idx == loc_idx))
      |=> (loc_rsp_cnt == seen_q && loc_rsp_ok && after_cnt == seen_q));

   // R3
   take_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && loc_op == 2'd1 && seen >= loc_amt && !(rmt_wr && rmt_idx == loc_idx))
      |=> (loc_rsp_ok && after_cnt == seen_q - $past(loc_amt)));

   // R4
   take_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && loc_op == 2'd1 && seen < loc_amt && !(rmt_wr && rmt_idx == loc_idx))
      |=> (!loc_rsp_ok && after_cnt == seen_q));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

   for (genvar s = 0; s < NSEM; s++) begin : g_per
      // R7
      depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_flat[s*CW +: CW] <= CW'(MAX_DEPTH));

      // R9
      untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!(loc_req && loc_idx == IDXW'(s) && loc_op inside {2'd1, 2'd2})
          && !(rmt_wr && rmt_idx == IDXW'(s)))
         |=> $stable(cnt_flat[s*CW +: CW]));
   end
endmodule

bind sem_bank sem_bank_chk #(
   .NSEM(NSEM), .CW(CW), .MAX_DEPTH(MAX_DEPTH), .IDXW(IDXW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .loc_req    (loc_req),
   .loc_op     (loc_op),
   .loc_idx    (loc_idx),
   .loc_amt    (loc_amt),
   .rmt_wr     (rmt_wr),
   .rmt_idx    (rmt_idx),
   .loc_rsp_vld(loc_rsp_vld),
   .loc_rsp_ok (loc_rsp_ok),
   .loc_rsp_cnt(loc_rsp_cnt),
   .ovf        (ovf),
   .cnt_flat   (cnt_flat)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
   localparam int NSEM = 8;
   localparam int CW   = 8;
   localparam int MAXD = 12;
   localparam int INIT = 4;
   localparam int IDXW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            loc_req = 1'b0;
   logic [1:0]      loc_op = '0;
   logic [IDXW-1:0] loc_idx = '0;
   logic [CW-1:0]   loc_amt = '0;
   logic            rmt_wr = 1'b0;
   logic [IDXW-1:0] rmt_idx = '0;
   logic [CW-1:0]   rmt_amt = '0;
   logic            loc_rsp_vld, loc_rsp_ok;
   logic [CW-1:0]   loc_rsp_cnt;
   logic [NSEM-1:0] ovf;

   int total = 0;
   int bad   = 0;

   int    ref_cnt [NSEM];
   bit    ref_ovf [NSEM];
   bit    exp_vld;
   bit    exp_ok;
   int    exp_cnt;
   string cur_tag = "R1";
   string exp_tag = "R1";

   always #5 clk = ~clk;

   sem_bank #(.NSEM(NSEM), .CW(CW), .MAX_DEPTH(MAXD), .INIT_CNT(INIT)) u_sem_bank (
      .clk(clk), .rst_n(rst_n),
      .loc_req(loc_req), .loc_op(loc_op), .loc_idx(loc_idx), .loc_amt(loc_amt),
      .rmt_wr(rmt_wr), .rmt_idx(rmt_idx), .rmt_amt(rmt_amt),
      .loc_rsp_vld(loc_rsp_vld), .loc_rsp_ok(loc_rsp_ok), .loc_rsp_cnt(loc_rsp_cnt),
      .ovf(ovf)
   );

   // behavioural reference, evaluated at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NSEM; s++) begin
            ref_cnt[s] = INIT;
            ref_ovf[s] = 1'b0;
         end
         exp_vld = 1'b0;
      end else begin
         int nxt [NSEM];
         int c;
         c = ref_cnt[loc_idx];
         exp_vld = loc_req;
         exp_tag = cur_tag;
         if (loc_req) begin
            exp_cnt = c;
            exp_ok  = (loc_op == 2'd1) ? (c >= int'(loc_amt)) : 1'b1;
         end
         for (int s = 0; s < NSEM; s++) begin
            nxt[s] = ref_cnt[s];
            if (loc_req && int'(loc_idx) == s) begin
               if (loc_op == 2'd1 && c >= int'(loc_amt)) nxt[s] -= int'(loc_amt);
               if (loc_op == 2'd2) nxt[s] += int'(loc_amt);
            end
            if (rmt_wr && int'(rmt_idx) == s) nxt[s] += int'(rmt_amt);
            if (nxt[s] > MAXD) begin
               nxt[s] = MAXD;
               ref_ovf[s] = 1'b1;
            end
            ref_cnt[s] = nxt[s];
         end
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // compare outputs at the falling edge
   task automatic compare();
      int ov;
      ov = 0;
      for (int s = 0; s < NSEM; s++) ov |= (int'(ref_ovf[s]) << s);
      check(exp_tag, "rsp_vld", int'(loc_rsp_vld), int'(exp_vld));
      if (exp_vld) begin
         check(exp_tag, "rsp_ok", int'(loc_rsp_ok), int'(exp_ok));
         check(exp_tag, "rsp_cnt", int'(loc_rsp_cnt), exp_cnt);
      end
      check(exp_vld ? exp_tag : "R7", "ovf", int'(ovf), ov);
   endtask

   task automatic step(input bit lr, input int op, input int li, input int la,
                       input bit rw, input int ri, input int ra, input string tag);
      @(negedge clk);
      compare();
      loc_req = lr;  loc_op = 2'(op);  loc_idx = IDXW'(li);  loc_amt = CW'(la);
      rmt_wr  = rw;  rmt_idx = IDXW'(ri); rmt_amt = CW'(ra);
      cur_tag = tag;
   endtask

   task automatic peek(input int idx, input string tag);
      step(1, 0, idx, 0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      check("R1", "rsp_vld in reset", int'(loc_rsp_vld), 0);
      check("R1", "ovf in reset", int'(ovf), 0);
      rst_n = 1'b1;
      for (int s = 0; s < NSEM; s++) peek(s, "R1");
      // R3 take that fits, R4 take that does not, then peek the count
      step(1, 1, 0, 3, 0, 0, 0, "R3");
      step(1, 1, 0, 2, 0, 0, 0, "R4");
      peek(0, "R4");
      // R2: op 3 acts as a peek
      step(1, 3, 0, 0, 0, 0, 0, "R2");
      // R5: remote add, no response, then visible
      step(0, 0, 0, 0, 1, 1, 5, "R5");
      peek(1, "R5");
      // R6: merged update, take judged before the add
      step(1, 1, 2, 4, 1, 2, 3, "R6");
      peek(2, "R6");
      step(1, 1, 3, 6, 1, 3, 5, "R6");
      peek(3, "R6");
      // R8: local give
      step(1, 2, 4, 2, 0, 0, 0, "R8");
      peek(4, "R8");
      // R7: clip at depth, sticky flag
      step(0, 0, 0, 0, 1, 5, 20, "R7");
      peek(5, "R7");
      step(1, 1, 5, 1, 0, 0, 0, "R7");
      peek(5, "R7");
      step(1, 2, 6, 9, 1, 6, 0, "R7");
      peek(6, "R7");
      // R9: distinct indices on both ports in one cycle
      step(1, 1, 7, 1, 1, 0, 2, "R9");
      peek(0, "R9");
      peek(7, "R9");
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 6)),
              bit'($urandom_range(0, 2) == 0), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 4)), "R9");
      end
      step(0, 0, 0, 0, 0, 0, 0, "R9");
      for (int s = 0; s < NSEM; s++) peek(s, "R9");
      step(0, 0, 0, 0, 0, 0, 0, "R9");
      @(negedge clk);
      compare();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule